// File: doc/BRIEF.md
# Two-Stage Timeout Watchdog

This block is a countdown watchdog that gives software one warning before it resets the system. The counter runs down on a tick enable. The first time it expires, the block sets a sticky timeout flag and reloads itself. While that flag is set, it can raise a system-management interrupt (SMI) request. If the counter expires a second time and nobody has cleared the flag, the block emits a one-cycle reset pulse. That pulse also returns every register of the block to its default. The worst-case hang before reset is therefore about two timer periods.

Software uses a small write/read register interface with byte offsets:

| Offset | Register | Fields |
|--------|----------|--------|
| 0x0 | SMI enable | bit 13: watchdog-source enable; bit 0: global gate |
| 0x4 | Status | bit 3: timeout flag, write 1 to clear |
| 0x8 | Control | bit 11: halt; bit 0: reload action |
| 0xC | Period | programmed period |

Clearing the flag re-arms the first stage, so an agent that only clears the flag keeps postponing the reset. A reload write restarts the count without touching the flag.

Top module: `wdog_two_stage`

## Requirements
- R1: After `rst`, and after every reset pulse the block emits itself, the registers hold their defaults: SMI enable reads 0, status reads 0, control reads 0, period reads DEF_PERIOD, the counter holds DEF_PERIOD, and `sysRstPulse` and `smiReq` are low.
- R2: The counter decrements once on each clock where `tickEn` is high and halt is clear. A tick that finds the counter at 0 is an expiry, so the first expiry comes on the (P+1)th tick after a load of period P. While `tickEn` is low, the counter holds.
- R3: An expiry while the timeout flag (status offset 0x4, bit 3) is clear sets the flag, reloads the counter with the period and does not pulse the reset.
- R4: An expiry while the timeout flag is set drives `sysRstPulse` high for exactly one cycle, starting on the next cycle.
- R5: `smiReq` is high only while the timeout flag is set and both SMI enable bits are 1: bit 13 (watchdog source) and bit 0 (global gate). If either bit is 0, `smiReq` stays low.
- R6: Writing 1 to status bit 3 clears the timeout flag, and writing 0 there leaves it unchanged. After a clear, the next expiry again only sets the flag, so the first stage is re-armed.
- R7: While control bit 11 (halt, mask 0x800) is set, the counter does not change. This bit reads back at bit 11 of offset 0x8.
- R8: Writing 1 to control bit 0 reloads the counter with the period and leaves the timeout flag unchanged. When a reload and a tick fall in the same cycle, the reload wins. Bit 0 always reads back as 0.
- R9: A write to the period register (offset 0xC) does not change a running count. The new value takes effect at the next reload or expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Count enable; one decrement per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Read byte offset |
| rdData | output | 32 | Read data for `rdAddr` (combinational) |
| smiReq | output | 1 | SMI request level |
| sysRstPulse | output | 1 | One-cycle system reset pulse |

## Verification
The assertions assume that the bus never writes the status clear in the same cycle as a first expiry. In that case the set takes priority, and the flag-clear property excludes it. The assertions also assume that `rst` is synchronous and held across at least one edge. The directed stimulus changes inputs only on the falling edge and issues one register write at a time. Each write is timed so that the expiry edges it aims at are counted from a known reload, so no write lands on an expiry cycle unless the test intends it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_SMIEN  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_PERIOD = 4'hC;

  localparam int BIT_GBL    = 0;
  localparam int BIT_SRC    = 13;
  localparam int BIT_FLAG   = 3;
  localparam int BIT_HALT   = 11;
  localparam int BIT_RELOAD = 0;

  typedef struct packed {
    logic ldSmiEn;
    logic ldPeriod;
    logic ldCtrl;
    logic reload;
    logic clrFlag;
    logic firstExp;
    logic secondExp;
  } wdogStrb_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              reloadBit,
  input  logic              clearBit,
  input  logic              cntZero,
  input  logic              flagQ,
  input  logic              haltQ,
  output wdogStrb_t         strb,
  output logic              rstPulseQ
);
  logic expire;

  always_comb begin
    strb          = '0;
    strb.ldSmiEn  = wrEn && (wrAddr == OFS_SMIEN);
    strb.ldPeriod = wrEn && (wrAddr == OFS_PERIOD);
    strb.ldCtrl   = wrEn && (wrAddr == OFS_CTRL);
    strb.reload   = strb.ldCtrl && reloadBit;
    strb.clrFlag  = wrEn && (wrAddr == OFS_STATUS) && clearBit;
    expire        = tickEn && !haltQ && cntZero && !strb.reload;
    strb.firstExp  = expire && !flagQ;
    strb.secondExp = expire && flagQ;
  end

  always_ff @(posedge clk) begin
    if (rst) rstPulseQ <= 1'b0;
    else     rstPulseQ <= strb.secondExp;
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int              CNT_W      = 16,
  parameter logic [CNT_W-1:0] DEF_PERIOD = 16'd40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  wdogStrb_t         strb,
  input  logic              srcEnIn,
  input  logic              gblEnIn,
  input  logic              haltIn,
  input  logic [CNT_W-1:0]  periodIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              cntZero,
  output logic              flagQ,
  output logic              haltQ,
  output logic              srcEnQ,
  output logic              gblEnQ,
  output logic [CNT_W-1:0]  cntQ
);
  logic [CNT_W-1:0] periodQ;
  logic             softRst;

  assign softRst = rst || strb.secondExp;
  assign cntZero = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (softRst) begin
      srcEnQ  <= 1'b0;
      gblEnQ  <= 1'b0;
      haltQ   <= 1'b0;
      flagQ   <= 1'b0;
      periodQ <= DEF_PERIOD;
      cntQ    <= DEF_PERIOD;
    end else begin
      if (strb.ldSmiEn) begin
        srcEnQ <= srcEnIn;
        gblEnQ <= gblEnIn;
      end
      if (strb.ldCtrl)   haltQ   <= haltIn;
      if (strb.ldPeriod) periodQ <= periodIn;
      if (strb.firstExp)     flagQ <= 1'b1;
      else if (strb.clrFlag) flagQ <= 1'b0;
      if (strb.reload || strb.firstExp) cntQ <= periodQ;
      else if (tickEn && !haltQ && !cntZero) cntQ <= cntQ - 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      OFS_SMIEN: begin
        rdData[BIT_SRC] = srcEnQ;
        rdData[BIT_GBL] = gblEnQ;
      end
      OFS_STATUS: rdData[BIT_FLAG] = flagQ;
      OFS_CTRL:   rdData[BIT_HALT] = haltQ;
      OFS_PERIOD: rdData = DATA_W'(periodQ);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] DEF_PERIOD = 16'd40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic [3:0]        rdAddr,
  output logic [31:0]       rdData,
  output logic              smiReq,
  output logic              sysRstPulse
);
  wdogStrb_t        strb;
  logic             cntZero, flagQ, haltQ, srcEnQ, gblEnQ;
  logic [CNT_W-1:0] cntQ;
  wire              unusedWrBits = &{1'b0, wrData};

  wdog_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tickEn    (tickEn),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .reloadBit (wrData[BIT_RELOAD]),
    .clearBit  (wrData[BIT_FLAG]),
    .cntZero   (cntZero),
    .flagQ     (flagQ),
    .haltQ     (haltQ),
    .strb      (strb),
    .rstPulseQ (sysRstPulse)
  );

  wdog_dp #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .strb     (strb),
    .srcEnIn  (wrData[BIT_SRC]),
    .gblEnIn  (wrData[BIT_GBL]),
    .haltIn   (wrData[BIT_HALT]),
    .periodIn (wrData[CNT_W-1:0]),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .cntZero  (cntZero),
    .flagQ    (flagQ),
    .haltQ    (haltQ),
    .srcEnQ   (srcEnQ),
    .gblEnQ   (gblEnQ),
    .cntQ     (cntQ)
  );

  assign smiReq = flagQ && srcEnQ && gblEnQ;
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sysRstPulse,
  input logic             smiReq,
  input logic             flagQ,
  input logic             haltQ,
  input logic             gblEnQ,
  input logic             srcEnQ,
  input logic [CNT_W-1:0] cntQ,
  input wdogStrb_t        strb
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sysRstPulse |=> !sysRstPulse); // R4
  AST_RST_AFTER_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(sysRstPulse) |-> $past(flagQ)); // R4
  AST_RST_CLEARS_STATE: assert property (@(posedge clk) disable iff (rst)
    sysRstPulse |-> (!flagQ && !haltQ && !gblEnQ && !srcEnQ)); // R1
  AST_NO_SMI_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    !gblEnQ |-> !smiReq); // R5
  AST_NO_SMI_SOURCE_OFF: assert property (@(posedge clk) disable iff (rst)
    !srcEnQ |-> !smiReq); // R5
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (haltQ && !strb.reload) |=> $stable(cntQ)); // R7
  AST_RELOAD_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (strb.reload && !strb.clrFlag) |=> $stable(flagQ)); // R8
  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (strb.clrFlag && !strb.firstExp && !strb.secondExp) |=> !flagQ); // R6
  AST_FIRST_NO_RST: assert property (@(posedge clk) disable iff (rst)
    strb.firstExp |=> (flagQ && !sysRstPulse)); // R3
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sysRstPulse (sysRstPulse),
  .smiReq      (smiReq),
  .flagQ       (flagQ),
  .haltQ       (haltQ),
  .gblEnQ      (gblEnQ),
  .srcEnQ      (srcEnQ),
  .cntQ        (cntQ),
  .strb        (strb)
);

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
  localparam logic [31:0] DEF_P = 32'd40;
  localparam logic [3:0] A_SMI = 4'h0, A_STS = 4'h4, A_CTL = 4'h8, A_PER = 4'hC;

  logic clk = 1'b0, rst = 1'b1, tickEn = 1'b1, wrEn = 1'b0;
  logic [3:0]  wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic smiReq, sysRstPulse;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  wdog_two_stage u_dut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .smiReq(smiReq),
    .sysRstPulse(sysRstPulse)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic waitTicks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic loadPeriod(input logic [31:0] p);
    busWr(A_PER, p);
    busWr(A_CTL, 32'h1);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(A_SMI, v); check("R1 smi enable default", v, 0);
    rd(A_STS, v); check("R1 status default", v, 0);
    rd(A_CTL, v); check("R1 control default", v, 0);
    rd(A_PER, v); check("R1 period default", v, DEF_P);
    check("R1 outputs low", {smiReq, sysRstPulse}, 0);
  endtask

  task automatic testTwoExpiries();
    logic [31:0] v;
    loadPeriod(5);
    waitTicks(5); rd(A_STS, v); check("R2 no expiry after P ticks", v, 0);
    waitTicks(1); rd(A_STS, v); check("R3 flag set on first expiry", v, 32'h8);
    check("R3 no reset on first expiry", sysRstPulse, 0);
    check("R5 smi low with enables off", smiReq, 0);
    waitTicks(5); check("R4 no reset before second expiry", sysRstPulse, 0);
    waitTicks(1); check("R4 reset pulse on second expiry", sysRstPulse, 1);
    rd(A_PER, v); check("R1 period default after pulse", v, DEF_P);
    rd(A_STS, v); check("R1 status default after pulse", v, 0);
    waitTicks(1); check("R4 reset pulse one cycle", sysRstPulse, 0);
  endtask

  task automatic testSmiGate();
    logic [31:0] vals [3] = '{32'h2001, 32'h2000, 32'h0001};
    for (int i = 0; i < 3; i++) begin
      busWr(A_SMI, vals[i]);
      loadPeriod(5);
      waitTicks(6);
      check("R5 smi gating with flag set", smiReq, (i == 0) ? 1 : 0);
      busWr(A_STS, 32'h8);
      check("R5 smi low after flag clear", smiReq, 0);
    end
    busWr(A_SMI, 0);
  endtask

  task automatic testW1c();
    logic [31:0] v;
    loadPeriod(5);
    waitTicks(6); rd(A_STS, v); check("R6 flag set before clear", v, 32'h8);
    busWr(A_STS, 32'hFFFF_FFF7);
    rd(A_STS, v); check("R6 writing 0 keeps flag", v, 32'h8);
    busWr(A_STS, 32'h8);
    rd(A_STS, v); check("R6 writing 1 clears flag", v, 0);
    waitTicks(3); rd(A_STS, v); check("R6 no early re-expiry", v, 0);
    waitTicks(1); rd(A_STS, v); check("R6 re-armed first stage sets flag", v, 32'h8);
    check("R6 re-armed expiry no reset", sysRstPulse, 0);
    busWr(A_STS, 32'h8);
  endtask

  task automatic testHalt();
    logic [31:0] v;
    loadPeriod(5);
    busWr(A_CTL, 32'h800);
    rd(A_CTL, v); check("R7 halt readback", v, 32'h800);
    waitTicks(20); rd(A_STS, v); check("R7 halted counter no expiry", v, 0);
    busWr(A_CTL, 32'h0);
    waitTicks(4); rd(A_STS, v); check("R7 count resumed from held value", v, 0);
    waitTicks(1); rd(A_STS, v); check("R7 expiry after resume", v, 32'h8);
    busWr(A_STS, 32'h8);
  endtask

  task automatic testReload();
    logic [31:0] v;
    loadPeriod(5);
    waitTicks(6);
    busWr(A_CTL, 32'h1);
    rd(A_STS, v); check("R8 reload keeps flag", v, 32'h8);
    rd(A_CTL, v); check("R8 reload bit reads 0", v, 0);
    waitTicks(5); check("R8 reload restarted full period", sysRstPulse, 0);
    waitTicks(1); check("R8 second expiry after reload", sysRstPulse, 1);
    waitTicks(1);
  endtask

  task automatic testTickGate();
    logic [31:0] v;
    loadPeriod(5);
    @(negedge clk) tickEn = 1'b0;
    waitTicks(20); rd(A_STS, v); check("R2 tickEn low holds count", v, 0);
    @(negedge clk) tickEn = 1'b1;
    waitTicks(5); rd(A_STS, v); check("R2 no expiry before P+1 ticks", v, 0);
    waitTicks(1); rd(A_STS, v); check("R2 expiry on tick P+1", v, 32'h8);
    busWr(A_STS, 32'h8);
  endtask

  task automatic testPeriodLatency();
    logic [31:0] v;
    loadPeriod(5);
    busWr(A_PER, 32'd2);
    waitTicks(4); rd(A_STS, v); check("R9 running count unaffected", v, 0);
    waitTicks(1); rd(A_STS, v); check("R9 expiry on old period", v, 32'h8);
    waitTicks(2); check("R9 new period not yet elapsed", sysRstPulse, 0);
    waitTicks(1); check("R9 new period used after expiry", sysRstPulse, 1);
    waitTicks(1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    testReset();
    testTwoExpiries();
    testSmiGate();
    testW1c();
    testHalt();
    testReload();
    testTickGate();
    testPeriodLatency();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule